// File: doc/BRIEF.md
# LCD Row Refresh Scanner

This block performs the display refresh for one 64-column segment driver. A 6-bit line counter tracks which display line is on the panel. A frame sync input loads it from a scroll start value, and a slow line clock advances it. After each change of the line counter, the block reads the 64 pixel bits of the new line out of a page-organised display RAM, one column byte at a time. It holds them in a gather buffer and copies them into the output latch on the next rising edge of the line clock.

Each of the 64 segment outputs is a 2-bit bias level code. The code depends on the latched pixel bit and on the frame alternation input. A column direction input mirrors the column order. A display enable flag, sampled only on the line clock, blanks every segment to its non-select level and leaves the RAM untouched. The line clock and frame sync are slow level inputs that are sampled in the `clk` domain. The RAM is an external synchronous read port with one cycle of latency.

Top module: `lcd_row_scanner`

## Requirements
- R1: While `rst_n` is low, the line counter is 0, the latched row is all zero and the latched enable flag is 0. Every segment then shows the non-select code for the current `alt_m`, and no RAM read is issued.
- R2: In every clock cycle where `frame_sync` is high, the line counter loads `start_line`, and a new row fetch begins on the following cycle. The next row latched is the row of the start line.
- R3: A falling edge of `line_clk` seen while `frame_sync` is low advances the line counter by one, and 63 wraps to 0. Without such an edge and without `frame_sync`, the counter holds its value.
- R4: The latched row and the latched display enable change only in the cycle that samples a rising edge of `line_clk`. A change of `disp_en` between rising edges has no effect on the segments.
- R5: A fetch starts one cycle after the line counter is loaded or advanced. It reads columns 0 to 63 in order at address {line[5:3], column[5:0]}, takes bit line[2:0] of each returned byte, and ends within 67 cycles. A `ram_re` cycle presents the address, and `ram_rdata` holds the byte one cycle later.
- R6: Segment s occupies `seg_lvl[2s+1:2s]`. With `col_dir`=1 it shows column s. With `col_dir`=0 it shows column 63-s.
- R7: While the display is enabled, the level code for each segment follows this table. `alt_m`=0 with pixel 1 gives 00. `alt_m`=0 with pixel 0 gives 01. `alt_m`=1 with pixel 0 gives 10. `alt_m`=1 with pixel 1 gives 11.
- R8: While the latched enable is 0, every segment shows 01 when `alt_m`=0 and 10 when `alt_m`=1, whatever the RAM holds.
- R9: Fetching continues while the display is disabled. Once enable is latched again, the segments show the stored pixels again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame sync; loads the line counter while high |
| line_clk | input | 1 | Line clock; rise latches the row, fall advances the line |
| alt_m | input | 1 | Frame alternation signal |
| col_dir | input | 1 | Column direction: 1 normal, 0 mirrored |
| disp_en | input | 1 | Display enable request, sampled on the line clock rise |
| start_line | input | 6 | Scroll start line |
| ram_re | output | 1 | Display RAM read strobe |
| ram_addr | output | 9 | Display RAM address {page, column} |
| ram_rdata | input | 8 | Display RAM read data, one cycle after the strobe |
| seg_lvl | output | 128 | Two-bit bias level code per segment |

## Verification
The segment outputs follow `alt_m` and `col_dir` within the same cycle. The latched row and the enable flag change only at the clock edge that samples a rising `line_clk`. The line counter moves at the edge that samples a falling `line_clk` or a high `frame_sync`, and the read strobe rises one edge after that, then runs for 64 cycles. The bench drives inputs on the falling clock edge and compares its model with every output 3 ns after each rising edge. It leaves at least 80 cycles between any line change and the next rising `line_clk`, so every latch sees a finished fetch. Directed checks sample the read strobe 2 cycles and 80 cycles after a falling `line_clk` to bracket the fetch window.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V3 = 2'b10,
    LVL_V5 = 2'b11
  } bias_lvl_e;

  // Bias selection from alternation phase and lit pixel.
  function automatic bias_lvl_e pick_level(input logic m, input logic lit);
    bias_lvl_e lv;
    case ({m, lit})
      2'b00:   lv = LVL_V2;
      2'b01:   lv = LVL_V0;
      2'b10:   lv = LVL_V3;
      default: lv = LVL_V5;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/lrs_line_ctr.sv
module lrs_line_ctr #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              line_clk,
  input  logic [LINE_W-1:0] start_line,
  output logic [LINE_W-1:0] line,
  output logic              line_upd,
  output logic              cl_rise,
  output logic              cl_fall
);

  logic cl_q;

  assign cl_rise = line_clk & ~cl_q;
  assign cl_fall = ~line_clk & cl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q     <= 1'b0;
      line     <= '0;
      line_upd <= 1'b0;
    end else begin
      cl_q     <= line_clk;
      line_upd <= frame_sync | cl_fall;
      if (frame_sync) begin
        line <= start_line;
      end else if (cl_fall) begin
        line <= line + LINE_W'(1);
      end
    end
  end

endmodule

// File: rtl/lrs_row_fetch.sv
module lrs_row_fetch #(
  parameter int NUM_SEG = 64,
  parameter int LINE_W  = 6,
  parameter int BYTE_W  = 8,
  localparam int COL_W  = $clog2(NUM_SEG),
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int PAGE_W = LINE_W - BIT_W,
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_W-1:0]  line,
  input  logic               line_upd,
  input  logic               cl_rise,
  input  logic               disp_en,
  output logic               ram_re,
  output logic [ADDR_W-1:0]  ram_addr,
  input  logic [BYTE_W-1:0]  ram_rdata,
  output logic [NUM_SEG-1:0] row_q,
  output logic               on_q
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_SEG - 1);

  logic               busy;
  logic [COL_W-1:0]   col;
  logic               rd_pend;
  logic [COL_W-1:0]   rd_col;
  logic [BIT_W-1:0]   rd_bit;
  logic [NUM_SEG-1:0] gather;

  assign ram_re   = busy;
  assign ram_addr = {line[LINE_W-1:BIT_W], col};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      col     <= '0;
      rd_pend <= 1'b0;
      rd_col  <= '0;
      rd_bit  <= '0;
      gather  <= '0;
      row_q   <= '0;
      on_q    <= 1'b0;
    end else begin
      if (line_upd) begin
        busy <= 1'b1;
        col  <= '0;
      end else if (busy) begin
        col <= col + COL_W'(1);
        if (col == LAST_COL) begin
          busy <= 1'b0;
        end
      end
      rd_pend <= busy & ~line_upd;
      rd_col  <= col;
      rd_bit  <= line[BIT_W-1:0];
      if (rd_pend) begin
        gather[rd_col] <= ram_rdata[rd_bit];
      end
      if (cl_rise) begin
        row_q <= gather;
        on_q  <= disp_en;
      end
    end
  end

endmodule

// File: rtl/lrs_seg_enc.sv
module lrs_seg_enc #(
  parameter int NUM_SEG = 64
) (
  input  logic [NUM_SEG-1:0]   row_q,
  input  logic                 on_q,
  input  logic                 alt_m,
  input  logic                 col_dir,
  output logic [2*NUM_SEG-1:0] seg_lvl
);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic pix;
    assign pix = col_dir ? row_q[s] : row_q[NUM_SEG-1-s];
    assign seg_lvl[2*s +: 2] = lrs_pkg::pick_level(alt_m, pix & on_q);
  end

endmodule

// File: rtl/lcd_row_scanner.sv
module lcd_row_scanner #(
  parameter int NUM_SEG   = 64,
  parameter int NUM_LINES = 64,
  parameter int BYTE_W    = 8,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int COL_W    = $clog2(NUM_SEG),
  localparam int BIT_W    = $clog2(BYTE_W),
  localparam int ADDR_W   = LINE_W - BIT_W + COL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_sync,
  input  logic                 line_clk,
  input  logic                 alt_m,
  input  logic                 col_dir,
  input  logic                 disp_en,
  input  logic [LINE_W-1:0]    start_line,
  output logic                 ram_re,
  output logic [ADDR_W-1:0]    ram_addr,
  input  logic [BYTE_W-1:0]    ram_rdata,
  output logic [2*NUM_SEG-1:0] seg_lvl
);

  // Named internal events, visible to the bound checker.
  logic [LINE_W-1:0]  line_w;
  logic               line_upd_w;
  logic               cl_rise_w;
  logic               cl_fall_w;
  logic [NUM_SEG-1:0] row_w;
  logic               on_w;

  lrs_line_ctr #(.LINE_W(LINE_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .line_clk   (line_clk),
    .start_line (start_line),
    .line       (line_w),
    .line_upd   (line_upd_w),
    .cl_rise    (cl_rise_w),
    .cl_fall    (cl_fall_w)
  );

  lrs_row_fetch #(.NUM_SEG(NUM_SEG), .LINE_W(LINE_W), .BYTE_W(BYTE_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (line_w),
    .line_upd  (line_upd_w),
    .cl_rise   (cl_rise_w),
    .disp_en   (disp_en),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_rdata (ram_rdata),
    .row_q     (row_w),
    .on_q      (on_w)
  );

  lrs_seg_enc #(.NUM_SEG(NUM_SEG)) u_enc (
    .row_q   (row_w),
    .on_q    (on_w),
    .alt_m   (alt_m),
    .col_dir (col_dir),
    .seg_lvl (seg_lvl)
  );

endmodule

// File: rtl/lcd_row_scanner_chk.sv
module lcd_row_scanner_chk #(
  parameter int NUM_SEG   = 64,
  parameter int NUM_LINES = 64,
  parameter int BYTE_W    = 8,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int COL_W    = $clog2(NUM_SEG),
  localparam int BIT_W    = $clog2(BYTE_W),
  localparam int ADDR_W   = LINE_W - BIT_W + COL_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_sync,
  input logic [LINE_W-1:0]    start_line,
  input logic                 alt_m,
  input logic                 col_dir,
  input logic                 ram_re,
  input logic [ADDR_W-1:0]    ram_addr,
  input logic [2*NUM_SEG-1:0] seg_lvl,
  input logic [LINE_W-1:0]    line,
  input logic                 line_upd,
  input logic                 cl_rise,
  input logic                 cl_fall,
  input logic [NUM_SEG-1:0]   row_q,
  input logic                 on_q
);

  logic [NUM_SEG-1:0] seg_hi;
  logic [NUM_SEG-1:0] seg_lo;
  logic [COL_W-1:0]   col_now;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_split
    assign seg_hi[s] = seg_lvl[2*s+1];
    assign seg_lo[s] = seg_lvl[2*s];
  end
  assign col_now = ram_addr[COL_W-1:0];

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (line == '0 && row_q == '0 && !on_q && !ram_re));

  a_r2_frame_preset: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> line == $past(start_line));

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_fall && !frame_sync) |=> line == $past(line) + LINE_W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl_fall && !frame_sync) |=> $stable(line));

  a_r4_row_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_rise |=> $stable(row_q));

  a_r4_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_rise |=> $stable(on_q));

  a_r5_fetch_start: assert property (@(posedge clk) disable iff (!rst_n)
    line_upd |=> (ram_re && col_now == '0));

  a_r5_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && !line_upd) |=> (!ram_re || col_now == $past(col_now) + COL_W'(1)));

  a_r6_edge_column: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> seg_lo[0] == ~(alt_m ^ (col_dir ? row_q[0] : row_q[NUM_SEG-1])));

  a_r7_phase_bit: assert property (@(posedge clk) disable iff (!rst_n)
    seg_hi == {NUM_SEG{alt_m}});

  a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |-> seg_lo == {NUM_SEG{~alt_m}});

endmodule

bind lcd_row_scanner lcd_row_scanner_chk #(
  .NUM_SEG(NUM_SEG), .NUM_LINES(NUM_LINES), .BYTE_W(BYTE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_sync (frame_sync),
  .start_line (start_line),
  .alt_m      (alt_m),
  .col_dir    (col_dir),
  .ram_re     (ram_re),
  .ram_addr   (ram_addr),
  .seg_lvl    (seg_lvl),
  .line       (line_w),
  .line_upd   (line_upd_w),
  .cl_rise    (cl_rise_w),
  .cl_fall    (cl_fall_w),
  .row_q      (row_w),
  .on_q       (on_w)
);

// File: tb/lcd_row_scanner_bench.sv
module lcd_row_scanner_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_sync = 1'b0;
  logic         line_clk = 1'b0;
  logic         alt_m = 1'b0;
  logic         col_dir = 1'b1;
  logic         disp_en = 1'b0;
  logic [5:0]   start_line = 6'd0;
  logic         ram_re;
  logic [8:0]   ram_addr;
  logic [7:0]   ram_rdata = 8'd0;
  logic [127:0] seg_lvl;

  always #4 clk = ~clk;

  lcd_row_scanner u_lcd_row_scanner (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .line_clk   (line_clk),
    .alt_m      (alt_m),
    .col_dir    (col_dir),
    .disp_en    (disp_en),
    .start_line (start_line),
    .ram_re     (ram_re),
    .ram_addr   (ram_addr),
    .ram_rdata  (ram_rdata),
    .seg_lvl    (seg_lvl)
  );

  logic [7:0] mem [0:511];
  always @(posedge clk) if (ram_re) ram_rdata <= mem[ram_addr];

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Requirement-level view of the level table.
  function automatic logic [1:0] code_of(input logic m, input logic lit);
    if (!m) return lit ? 2'b00 : 2'b01;
    return lit ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [63:0] row_of(input int ln);
    logic [63:0] r;
    for (int c = 0; c < 64; c++) r[c] = mem[(ln / 8) * 64 + c][ln % 8];
    return r;
  endfunction

  function automatic logic [127:0] segs_of(input logic [63:0] r, input bit on,
                                           input logic m, input logic dir);
    logic [127:0] v;
    for (int s = 0; s < 64; s++) begin
      int c;
      c = dir ? s : 63 - s;
      v[2*s +: 2] = code_of(m, on && r[c]);
    end
    return v;
  endfunction

  // Behavioural reference model, compared 3 ns after every rising edge.
  int          m_line = 0;
  logic [63:0] m_row = '0;
  bit          m_on = 1'b0;
  bit          m_clp = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 0; m_row = '0; m_on = 1'b0; m_clp = 1'b0;
    end else begin
      if (line_clk && !m_clp) begin
        m_row = row_of(m_line);
        m_on  = disp_en;
      end
      if (frame_sync) m_line = start_line;
      else if (!line_clk && m_clp) m_line = (m_line + 1) % 64;
      m_clp = line_clk;
    end
    #3;
    chk("R6 R7 R8 per-cycle segments", seg_lvl, segs_of(m_row, m_on, alt_m, col_dir));
  end

  task automatic frame(input logic [5:0] sl);
    @(negedge clk);
    start_line = sl;
    frame_sync = 1'b1;
    repeat (2) @(negedge clk);
    frame_sync = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic pulse_line(input logic m);
    @(negedge clk);
    line_clk = 1'b1;
    alt_m = m;
    repeat (4) @(negedge clk);
    line_clk = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 fetch running after fall", {127'd0, ram_re}, 128'd1);
    repeat (78) @(negedge clk);
    chk("R5 fetch finished", {127'd0, ram_re}, 128'd0);
  endtask

  initial begin
    for (int a = 0; a < 512; a++) mem[a] = 8'((a * 29 + 7) ^ (a >> 2));
    mem[0][5] = 1'b1;
    mem[1][5] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset blank", seg_lvl, {64{2'b01}});
    chk("R1 no read in reset", {127'd0, ram_re}, 128'd0);
    rst_n = 1'b1;
    disp_en = 1'b1;

    frame(6'd0);
    pulse_line(1'b0);
    chk("R2 start line row", {126'd0, seg_lvl[1:0]}, {126'd0, code_of(1'b0, mem[0][0])});
    @(negedge clk); col_dir = 1'b0;
    @(negedge clk);
    chk("R6 mirrored edge", {126'd0, seg_lvl[1:0]}, {126'd0, code_of(1'b0, mem[63][0])});
    col_dir = 1'b1;
    for (int i = 0; i < 8; i++) pulse_line(i[0]);

    frame(6'd62);
    pulse_line(1'b0);
    pulse_line(1'b1);
    pulse_line(1'b0);
    chk("R3 wrap to line 0", {126'd0, seg_lvl[1:0]}, {126'd0, code_of(1'b0, mem[0][0])});

    frame(6'd5);
    pulse_line(1'b0);
    chk("R7 m0 lit", {126'd0, seg_lvl[1:0]}, {126'd0, 2'b00});
    chk("R7 m0 dark", {126'd0, seg_lvl[3:2]}, {126'd0, 2'b01});
    @(negedge clk); alt_m = 1'b1;
    @(negedge clk);
    chk("R7 m1 lit", {126'd0, seg_lvl[1:0]}, {126'd0, 2'b11});
    chk("R7 m1 dark", {126'd0, seg_lvl[3:2]}, {126'd0, 2'b10});

    disp_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 enable held until rise", {126'd0, seg_lvl[1:0]}, {126'd0, 2'b11});
    pulse_line(1'b1);
    chk("R8 all non-select", seg_lvl, {64{2'b10}});

    disp_en = 1'b1;
    frame(6'd5);
    pulse_line(1'b1);
    chk("R9 pixels restored", {126'd0, seg_lvl[1:0]}, {126'd0, 2'b11});

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run blank", seg_lvl, {64{2'b10}});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule